// File: doc/BRIEF.md
# Strobe-Committed Serial Register Slave

This block is a small register file that a host reaches over three serial wires (clock, data toward the block, data from the block) plus an active-low strobe. The host shifts bits in on the serial clock. It then pulses the strobe with one serial clock pulse inside it. The level on the data input at that clock pulse selects the operation. A low level reads: the addressed register is loaded into an output shifter, and the host clocks that shifter out. A high level writes: the shifted-in data word is stored into the addressed register.

The block holds a mode word, a multiplexer word, a switch input, a reset-control register and a version constant. A write of a set bit 0 to the reset-control register raises a reset-request output for a fixed number of system clocks. The serial pins are asynchronous to the system clock. They pass through two-flop synchronizers, and every edge is detected in the system clock domain. There is no streaming payload here, so no valid/ready handshake appears. The serial lines are paced by the host, and the block keeps up with any serial clock slower than about a quarter of the system clock.

Top module: `serstb_regfile`

## Requirements
- R1: After reset, ser_dout is 1, rst_req is 0, mode_word equals MODE_INIT and mux_word equals MUX_INIT.
- R2: Each serial clock rising edge seen while the strobe is high shifts ser_din into one 40-bit chain, MSB first. The last 8 bits form the address and the 32 bits before them form the data word. Any earlier bits are discarded.
- R3: The first serial clock rising edge while the strobe is low commits exactly one operation: ser_din 0 reads, ser_din 1 writes. Further clock pulses within the same strobe low period do nothing.
- R4: A read places wire bit 31 of the addressed word on ser_dout. Each serial clock falling edge while the strobe is high then moves to the next lower bit. After all 32 bits, ser_dout returns to 1.
- R5: Words travel on the wire with their bytes reversed. A wire word W is held as the native value whose byte 0 is W[31:24], so mode_word and mux_word show the native value, and a read returns the same wire word that was written.
- R6: Address 0x00 is the read/write mode word. 0x02 is the read/write multiplexer word. 0x08 reads the zero-extended switch input as a native value. 0x80 is the read/write reset-control register. 0xFF reads the VERSION native value.
- R7: Writes to 0x08, 0xFF and any unmapped address change no register. A read of an unmapped address returns a wire word of all zeros.
- R8: A write to 0x80 whose native bit 0 (wire bit 24) is set raises rst_req for exactly RST_PULSE system clocks. After that the reset-control register reads back as zero.
- R9: A write to 0x80 with native bit 0 clear stores the value and leaves rst_req low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock from host, idles low |
| ser_stb_n | input | 1 | Active-low commit strobe, idles high |
| ser_din | input | 1 | Serial data toward the block; read/write select during the strobe |
| ser_dout | output | 1 | Serial data toward the host, high when idle |
| dip_sw | input | DIP_W | Switch levels presented at address 0x08 |
| mode_word | output | DW | Native value of the mode register |
| mux_word | output | DW | Native value of the multiplexer register |
| rst_req | output | 1 | Reset-request pulse |

## Verification
The bench builds the block with RST_PULSE set to 20. At that length it can count the request pulse cycle by cycle and confirm that the reset-control register clears right after. DIP_W is 8 with a switch pattern that does not read the same after byte reversal. VERSION and MODE_INIT are set to asymmetric values, so any mistake in byte order or in the mapping of reads shows up directly at the serial output and the parallel outputs.

// File: rtl/serstb_pkg.sv
package serstb_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } serstb_op_e;

  localparam logic [7:0] ADDR_MODE    = 8'h00;
  localparam logic [7:0] ADDR_MUX     = 8'h02;
  localparam logic [7:0] ADDR_SWITCH  = 8'h08;
  localparam logic [7:0] ADDR_RSTCTL  = 8'h80;
  localparam logic [7:0] ADDR_VERSION = 8'hFF;

endpackage

// File: rtl/serstb_sync.sv
module serstb_sync #(
  parameter int          N       = 3,
  parameter int          STAGES  = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] level
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[i]}};
      else        chain <= {chain[STAGES-2:0], async_in[i]};
    end

    assign level[i] = chain[STAGES-1];
  end

endmodule

// File: rtl/serstb_shifter.sv
module serstb_shifter
  import serstb_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk_lvl,
  input  logic          stb_n_lvl,
  input  logic          sdi_lvl,
  input  logic [DW-1:0] rd_wire,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] wr_wire,
  output serstb_op_e    cmd,
  output logic          sdo
);

  logic          sclk_d;
  logic          armed;
  logic          sclk_rise, sclk_fall;
  logic          commit, shift_in, shift_out;
  logic [AW-1:0] addr_sr;
  logic [DW-1:0] data_sr;
  logic [DW-1:0] out_sr;

  assign sclk_rise = sclk_lvl & ~sclk_d;
  assign sclk_fall = ~sclk_lvl & sclk_d;
  assign commit    = sclk_rise & ~stb_n_lvl & armed;
  assign shift_in  = sclk_rise & stb_n_lvl;
  assign shift_out = sclk_fall & stb_n_lvl;

  always_comb begin
    cmd = OP_NONE;
    if (commit) cmd = sdi_lvl ? OP_WRITE : OP_READ;
  end

  // edge history and one-commit-per-strobe guard
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      armed  <= 1'b1;
    end else begin
      sclk_d <= sclk_lvl;
      if (stb_n_lvl)   armed <= 1'b1;
      else if (commit) armed <= 1'b0;
    end
  end

  // cascaded input chain: address is the newest AW bits
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_sr <= '0;
      data_sr <= '0;
    end else if (shift_in) begin
      addr_sr <= {addr_sr[AW-2:0], sdi_lvl};
      data_sr <= {data_sr[DW-2:0], addr_sr[AW-1]};
    end
  end

  // output shifter, refilled with ones so the idle level is high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               out_sr <= '1;
    else if (cmd == OP_READ)  out_sr <= rd_wire;
    else if (shift_out)       out_sr <= {out_sr[DW-2:0], 1'b1};
  end

  assign addr    = addr_sr;
  assign wr_wire = data_sr;
  assign sdo     = out_sr[DW-1];

  a_r3_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != OP_NONE) |=> (cmd == OP_NONE));

  a_r4_dout_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_out && cmd != OP_READ) |=> $stable(sdo));

  a_r2_addr_frozen_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb_n_lvl) |=> $stable(addr));

endmodule

// File: rtl/serstb_regmap.sv
module serstb_regmap
  import serstb_pkg::*;
#(
  parameter int          AW        = 8,
  parameter int          DW        = 32,
  parameter int          DIP_W     = 8,
  parameter int          RST_PULSE = 1000,
  parameter logic [DW-1:0] VERSION   = 32'h0001_0000,
  parameter logic [DW-1:0] MODE_INIT = '0,
  parameter logic [DW-1:0] MUX_INIT  = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  serstb_op_e       cmd,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wr_wire,
  input  logic [DIP_W-1:0] dip_sw,
  output logic [DW-1:0]    rd_wire,
  output logic [DW-1:0]    mode_word,
  output logic [DW-1:0]    mux_word,
  output logic             rst_req
);

  localparam int NB    = DW / 8;
  localparam int CNT_W = $clog2(RST_PULSE + 1);

  localparam logic [AW-1:0] A_MODE = AW'(ADDR_MODE);
  localparam logic [AW-1:0] A_MUX  = AW'(ADDR_MUX);
  localparam logic [AW-1:0] A_SW   = AW'(ADDR_SWITCH);
  localparam logic [AW-1:0] A_RST  = AW'(ADDR_RSTCTL);
  localparam logic [AW-1:0] A_VER  = AW'(ADDR_VERSION);

  function automatic logic [DW-1:0] flip_bytes(input logic [DW-1:0] w);
    logic [DW-1:0] r;
    for (int b = 0; b < NB; b++) r[8*b +: 8] = w[8*(NB-1-b) +: 8];
    return r;
  endfunction

  logic [DW-1:0]    native_in, rd_native, sw_native;
  logic [DW-1:0]    mode_q, mux_q, rst_q;
  logic [CNT_W-1:0] rst_cnt;
  logic             wr;

  assign native_in = flip_bytes(wr_wire);
  assign wr        = (cmd == OP_WRITE);

  if (DIP_W < DW) begin : g_sw_pad
    assign sw_native = {{(DW-DIP_W){1'b0}}, dip_sw};
  end else begin : g_sw_full
    assign sw_native = dip_sw[DW-1:0];
  end

  always_comb begin
    if      (addr == A_MODE) rd_native = mode_q;
    else if (addr == A_MUX)  rd_native = mux_q;
    else if (addr == A_SW)   rd_native = sw_native;
    else if (addr == A_RST)  rd_native = rst_q;
    else if (addr == A_VER)  rd_native = VERSION;
    else                     rd_native = '0;
  end

  assign rd_wire = flip_bytes(rd_native);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_INIT;
      mux_q  <= MUX_INIT;
    end else if (wr) begin
      if (addr == A_MODE) mode_q <= native_in;
      if (addr == A_MUX)  mux_q  <= native_in;
    end
  end

  // reset-control register with self-clearing request pulse
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q   <= '0;
      rst_cnt <= '0;
    end else if (wr && addr == A_RST) begin
      rst_q   <= native_in;
      rst_cnt <= native_in[0] ? CNT_W'(RST_PULSE) : '0;
    end else if (rst_cnt != '0) begin
      rst_cnt <= rst_cnt - 1'b1;
      if (rst_cnt == CNT_W'(1)) rst_q <= '0;
    end
  end

  assign rst_req   = (rst_cnt != '0);
  assign mode_word = mode_q;
  assign mux_word  = mux_q;

  a_r8_rise_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> $past(cmd == OP_WRITE && addr == A_RST));

  a_r8_clear_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> (rst_req || !rst_q[0]));

  a_r7_mode_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd == OP_WRITE && addr == A_MODE) |=> $stable(mode_word));

  a_r7_mux_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd == OP_WRITE && addr == A_MUX) |=> $stable(mux_word));

endmodule

// File: rtl/serstb_regfile.sv
module serstb_regfile
  import serstb_pkg::*;
#(
  parameter int          DW        = 32,
  parameter int          DIP_W     = 8,
  parameter int          SYNC_STG  = 2,
  parameter int          RST_PULSE = 1000,
  parameter logic [DW-1:0] VERSION   = 32'h0001_0000,
  parameter logic [DW-1:0] MODE_INIT = '0,
  parameter logic [DW-1:0] MUX_INIT  = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_clk,
  input  logic             ser_stb_n,
  input  logic             ser_din,
  output logic             ser_dout,
  input  logic [DIP_W-1:0] dip_sw,
  output logic [DW-1:0]    mode_word,
  output logic [DW-1:0]    mux_word,
  output logic             rst_req
);

  localparam int AW = 8;

  logic [2:0]    pins_lvl;
  logic [AW-1:0] addr;
  logic [DW-1:0] wr_wire, rd_wire;
  serstb_op_e    cmd;

  // bit 0 serial clock, bit 1 strobe, bit 2 data in
  serstb_sync #(.N(3), .STAGES(SYNC_STG), .RST_VAL(3'b010)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({ser_din, ser_stb_n, ser_clk}),
    .level    (pins_lvl)
  );

  serstb_shifter #(.AW(AW), .DW(DW)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_lvl  (pins_lvl[0]),
    .stb_n_lvl (pins_lvl[1]),
    .sdi_lvl   (pins_lvl[2]),
    .rd_wire   (rd_wire),
    .addr      (addr),
    .wr_wire   (wr_wire),
    .cmd       (cmd),
    .sdo       (ser_dout)
  );

  serstb_regmap #(
    .AW(AW), .DW(DW), .DIP_W(DIP_W), .RST_PULSE(RST_PULSE),
    .VERSION(VERSION), .MODE_INIT(MODE_INIT), .MUX_INIT(MUX_INIT)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd       (cmd),
    .addr      (addr),
    .wr_wire   (wr_wire),
    .dip_sw    (dip_sw),
    .rd_wire   (rd_wire),
    .mode_word (mode_word),
    .mux_word  (mux_word),
    .rst_req   (rst_req)
  );

endmodule

// File: tb/serstb_regfile_test.sv
`timescale 1ns/1ps
module serstb_regfile_test;

  localparam int          H       = 6;
  localparam int          PULSE   = 20;
  localparam logic [31:0] VER     = 32'hA5C3_0107;
  localparam logic [31:0] MODE0   = 32'h0000_1234;
  localparam logic [31:0] MUX0    = 32'h0000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ser_clk = 1'b0, ser_stb_n = 1'b1, ser_din = 1'b0;
  logic        ser_dout;
  logic [7:0]  dip_sw = 8'h5A;
  logic [31:0] mode_word, mux_word;
  logic        rst_req;

  int n_checks = 0, n_fail = 0, pulse_cycles = 0, cyc = 0;

  always #10 clk = ~clk;

  serstb_regfile #(
    .DW(32), .DIP_W(8), .SYNC_STG(2), .RST_PULSE(PULSE),
    .VERSION(VER), .MODE_INIT(MODE0), .MUX_INIT(MUX0)
  ) uut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_stb_n(ser_stb_n),
    .ser_din(ser_din), .ser_dout(ser_dout), .dip_sw(dip_sw),
    .mode_word(mode_word), .mux_word(mux_word), .rst_req(rst_req)
  );

  always @(posedge clk) if (rst_req) pulse_cycles <= pulse_cycles + 1;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_checks++; n_fail++;
      $display("FAIL R3 watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  function automatic logic [31:0] rev(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ser_bit(input logic b, output logic seen);
    ser_din = b;
    wait_clk(H);
    seen = ser_dout;
    ser_clk = 1'b1;
    wait_clk(H);
    ser_clk = 1'b0;
  endtask

  task automatic strobe(input logic rw, input int pulses, input logic rw2);
    ser_stb_n = 1'b0;
    for (int p = 0; p < pulses; p++) begin
      ser_din = (p == 0) ? rw : rw2;
      wait_clk(H);
      ser_clk = 1'b1;
      wait_clk(H);
      ser_clk = 1'b0;
    end
    wait_clk(H);
    ser_stb_n = 1'b1;
    wait_clk(H);
  endtask

  task automatic shift_bits(input logic [39:0] v, input int n);
    logic s;
    for (int i = n - 1; i >= 0; i--) ser_bit(v[i], s);
  endtask

  task automatic write_reg(input logic [7:0] a, input logic [31:0] w);
    shift_bits({w, a}, 40);
    strobe(1'b1, 1, 1'b1);
    wait_clk(H);
  endtask

  task automatic read_reg(input logic [7:0] a, output logic [31:0] w);
    logic s;
    shift_bits({32'h0, a}, 8);
    strobe(1'b0, 1, 1'b0);
    for (int i = 31; i >= 0; i--) begin
      ser_bit(1'b0, s);
      w[i] = s;
    end
    wait_clk(H);
  endtask

  task automatic t_reset;
    check("R1 dout idle", {31'h0, ser_dout}, 32'h1);
    check("R1 rst_req", {31'h0, rst_req}, 32'h0);
    check("R1 mode init", mode_word, MODE0);
    check("R1 mux init", mux_word, MUX0);
  endtask

  task automatic t_mode_rw;
    logic [31:0] r;
    read_reg(8'h00, r);
    check("R5 mode init wire order", r, rev(MODE0));
    write_reg(8'h00, 32'h1122_3344);
    check("R5 mode native", mode_word, 32'h4433_2211);
    read_reg(8'h00, r);
    check("R6 mode readback", r, 32'h1122_3344);
    check("R4 dout high after read", {31'h0, ser_dout}, 32'h1);
  endtask

  task automatic t_mux_extra_bits;
    logic [31:0] r;
    shift_bits(40'h0B, 5);
    write_reg(8'h02, 32'hCAFE_F00D);
    check("R2 mux native after extra bits", mux_word, rev(32'hCAFE_F00D));
    shift_bits(40'h3, 3);
    read_reg(8'h02, r);
    check("R2 mux readback", r, 32'hCAFE_F00D);
  endtask

  task automatic t_readonly;
    logic [31:0] r;
    read_reg(8'h08, r);
    check("R6 switch read", r, 32'h5A00_0000);
    read_reg(8'hFF, r);
    check("R6 version read", r, rev(VER));
    write_reg(8'hFF, 32'hFFFF_FFFF);
    write_reg(8'h08, 32'hFFFF_FFFF);
    write_reg(8'h03, 32'hFFFF_FFFF);
    read_reg(8'hFF, r);
    check("R7 version unchanged", r, rev(VER));
    read_reg(8'h08, r);
    check("R7 switch unchanged", r, 32'h5A00_0000);
    check("R7 mode unchanged", mode_word, 32'h4433_2211);
    check("R7 mux unchanged", mux_word, rev(32'hCAFE_F00D));
    read_reg(8'h01, r);
    check("R7 unmapped read zero", r, 32'h0);
    check("R7 no reset request", {31'h0, rst_req}, 32'h0);
  endtask

  task automatic t_single_commit;
    logic [31:0] r;
    shift_bits({32'hDEAD_BEEF, 8'h00}, 40);
    strobe(1'b0, 2, 1'b1);
    wait_clk(H);
    check("R3 second pulse ignored", mode_word, 32'h4433_2211);
    read_reg(8'h00, r);
    check("R3 mode after double pulse", r, 32'h1122_3344);
  endtask

  task automatic t_reset_pulse;
    logic [31:0] r;
    pulse_cycles = 0;
    write_reg(8'h80, 32'h0200_0000);
    wait_clk(4 * PULSE);
    check("R9 no pulse for bit0 clear", pulse_cycles, 0);
    read_reg(8'h80, r);
    check("R9 stored value", r, 32'h0200_0000);
    pulse_cycles = 0;
    write_reg(8'h80, 32'h0100_0000);
    wait_clk(4 * PULSE);
    check("R8 pulse length", pulse_cycles, PULSE);
    check("R8 request low after pulse", {31'h0, rst_req}, 32'h0);
    read_reg(8'h80, r);
    check("R8 register cleared", r, 32'h0);
  endtask

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    t_reset();
    t_mode_rw();
    t_mux_extra_bits();
    t_readonly();
    t_single_commit();
    t_reset_pulse();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule